// File: doc/BRIEF.md
# No-Load Energy Accumulation Gate

This block sits between the per-phase power calculation and the energy accumulators of a three-phase metering datapath. Each valid power sample brings an active power and a reactive power value for every phase. The block compares the magnitude of each value with a programmable threshold. When a phase carries too little power to be counted, the block forces that phase's gated samples to zero. The accumulators downstream then add nothing for that phase and produce no pulses from it. This removes creep in the meter when voltage is applied but no load current flows.

Two 24-bit signed thresholds are used, one for active power and one for reactive power. Both are sign-extended into the 28-bit power datapath. A negative active threshold turns detection off. A negative reactive threshold removes the reactive term, so meters that measure only active power still get a working gate. Every phase is judged on its own. The per-phase no-load flags and the gated samples are registered, and they change only on a valid sample.

Top module: `noload_gate`

## Requirements
- R1: After reset, `m_valid`, every `noload` bit and every gated power output are zero.
- R2: `m_valid` rises exactly one clock after a cycle with `s_valid` high and is low otherwise. Flags and gated outputs change only on the clock edge after a valid sample and hold their value at all other times.
- R3: With both thresholds non-negative, the flag of a phase is set when |active| ≤ active threshold and |reactive| ≤ reactive threshold. Equality counts as no-load, including a threshold of zero with zero samples.
- R4: When either magnitude of a phase exceeds its threshold, that phase's flag is low and both of its samples pass to the outputs unchanged.
- R5: While a phase's flag is set, both of its gated outputs (active and reactive) are zero.
- R6: Thresholds are 24-bit two's-complement values, sign-extended to the 28-bit sample width before comparison. The largest positive threshold 0x7FFFFF accepts a magnitude of 0x7FFFFF and rejects 0x800000.
- R7: Magnitudes are taken on 28-bit two's-complement samples. A negative sample is judged by its absolute value, and the most negative sample 0x8000000 saturates to 0x7FFFFFF, so it never counts as below threshold.
- R8: When the active threshold is negative (bit 23 set), detection is off for all phases, whatever the reactive threshold is. Every flag is low and every sample passes unchanged.
- R9: When the active threshold is non-negative and the reactive threshold is negative, the flag depends only on |active| ≤ active threshold.
- R10: Phases are evaluated independently. Phase p occupies bits [28p+27:28p] of each packed sample port and bit p of `noload`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Power samples on the inputs are valid this cycle |
| act_pwr | input | 84 | Packed signed active power samples, phase p at [28p+27:28p] |
| rea_pwr | input | 84 | Packed signed reactive power samples, same packing |
| act_thr | input | 24 | Signed active power no-load threshold |
| rea_thr | input | 24 | Signed reactive power no-load threshold |
| m_valid | output | 1 | Gated outputs were updated on the last edge |
| act_gated | output | 84 | Gated active power samples, same packing |
| rea_gated | output | 84 | Gated reactive power samples, same packing |
| noload | output | 3 | Per-phase no-load flag |

## Verification
The bench places magnitudes exactly on each threshold and one step above it. A strict comparison would leave equal-valued phases running, and a one-off error would gate a phase that should count. It drives the most negative sample against the widest threshold: a non-saturating absolute value wraps to a negative number and, under a signed compare, would wrongly gate. It also uses threshold 0x800000 and negative active thresholds to expose a design that zero-extends instead of sign-extending, or that ignores either disable path. Mixed per-phase patterns and idle cycles with changing inputs catch crossed phase slices and outputs that follow the inputs without `s_valid`.

// File: rtl/nlg_pkg.sv
package nlg_pkg;

  // Detection mode derived from the threshold signs
  typedef enum logic [1:0] {
    NL_OFF      = 2'd0,  // active threshold negative: no gating
    NL_ACT_ONLY = 2'd1,  // reactive threshold negative: active term only
    NL_BOTH     = 2'd2   // both terms must be under threshold
  } nl_mode_t;

endpackage

// File: rtl/nlg_abs_sat.sv
module nlg_abs_sat #(
  parameter int DW = 28
) (
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] mag_o
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    if (val_i == MOST_NEG)
      mag_o = MOST_POS;
    else if (val_i[DW-1])
      mag_o = (~val_i) + {{(DW-1){1'b0}}, 1'b1};
    else
      mag_o = val_i;
  end
endmodule

// File: rtl/nlg_thr_ext.sv
module nlg_thr_ext #(
  parameter int TW = 24,
  parameter int DW = 28
) (
  input  logic [TW-1:0] thr_i,
  output logic [DW-1:0] thr_o,
  output logic          neg_o
);
  localparam int EXT = DW - TW;

  assign thr_o = {{EXT{thr_i[TW-1]}}, thr_i};
  assign neg_o = thr_i[TW-1];
endmodule

// File: rtl/nlg_phase.sv
module nlg_phase
  import nlg_pkg::*;
#(
  parameter int DW = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  nl_mode_t      mode,
  input  logic [DW-1:0] act_i,
  input  logic [DW-1:0] rea_i,
  input  logic [DW-1:0] act_thr,
  input  logic [DW-1:0] rea_thr,
  output logic          noload_o,
  output logic [DW-1:0] act_o,
  output logic [DW-1:0] rea_o
);
  logic [DW-1:0] act_mag, rea_mag;
  logic          act_low, rea_low, nl_next;

  nlg_abs_sat #(.DW(DW)) u_abs_act (.val_i(act_i), .mag_o(act_mag));
  nlg_abs_sat #(.DW(DW)) u_abs_rea (.val_i(rea_i), .mag_o(rea_mag));

  // Thresholds are non-negative whenever they are used, so an unsigned compare is exact
  always_comb begin
    act_low = (mode != NL_OFF) && (act_mag <= act_thr);
    rea_low = (mode == NL_ACT_ONLY) || (rea_mag <= rea_thr);
    nl_next = act_low && rea_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      noload_o <= 1'b0;
      act_o    <= '0;
      rea_o    <= '0;
    end else if (en) begin
      noload_o <= nl_next;
      act_o    <= nl_next ? '0 : act_i;
      rea_o    <= nl_next ? '0 : rea_i;
    end
  end

  assert_gate_zero_R5: assert property (@(posedge clk) disable iff (rst)
    noload_o |-> (act_o == '0 && rea_o == '0));

  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    (en && mode == NL_OFF) |=> !noload_o);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(noload_o) && $stable(act_o) && $stable(rea_o)));

  assert_mag_sign_R7: assert property (@(posedge clk) disable iff (rst)
    en |-> (!act_mag[DW-1] && !rea_mag[DW-1]));

  assert_pass_R4: assert property (@(posedge clk) disable iff (rst)
    en |=> (noload_o || (act_o == $past(act_i) && rea_o == $past(rea_i))));
endmodule

// File: rtl/noload_gate.sv
module noload_gate
  import nlg_pkg::*;
#(
  parameter int NPH = 3,
  parameter int DW  = 28,
  parameter int TW  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic [NPH*DW-1:0] act_pwr,
  input  logic [NPH*DW-1:0] rea_pwr,
  input  logic [TW-1:0]    act_thr,
  input  logic [TW-1:0]    rea_thr,
  output logic             m_valid,
  output logic [NPH*DW-1:0] act_gated,
  output logic [NPH*DW-1:0] rea_gated,
  output logic [NPH-1:0]   noload
);
  logic [DW-1:0] act_thr_x, rea_thr_x;
  logic          act_neg, rea_neg;
  nl_mode_t      mode;

  nlg_thr_ext #(.TW(TW), .DW(DW)) u_ext_act (
    .thr_i(act_thr), .thr_o(act_thr_x), .neg_o(act_neg));
  nlg_thr_ext #(.TW(TW), .DW(DW)) u_ext_rea (
    .thr_i(rea_thr), .thr_o(rea_thr_x), .neg_o(rea_neg));

  always_comb begin
    if (act_neg)      mode = NL_OFF;
    else if (rea_neg) mode = NL_ACT_ONLY;
    else              mode = NL_BOTH;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    nlg_phase #(.DW(DW)) u_ph (
      .clk     (clk),
      .rst     (rst),
      .en      (s_valid),
      .mode    (mode),
      .act_i   (act_pwr[p*DW +: DW]),
      .rea_i   (rea_pwr[p*DW +: DW]),
      .act_thr (act_thr_x),
      .rea_thr (rea_thr_x),
      .noload_o(noload[p]),
      .act_o   (act_gated[p*DW +: DW]),
      .rea_o   (rea_gated[p*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) m_valid <= 1'b0;
    else     m_valid <= s_valid;
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    s_valid |=> m_valid);

  assert_valid_low_R2: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> !m_valid);

  assert_flag_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> $stable(noload));
endmodule

// File: tb/noload_gate_tb.sv
module noload_gate_tb;
  localparam int NPH = 3;
  localparam int DW  = 28;
  localparam int TW  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic [NPH*DW-1:0] act_pwr = '0, rea_pwr = '0;
  logic [TW-1:0] act_thr = '0, rea_thr = '0;
  logic m_valid;
  logic [NPH*DW-1:0] act_gated, rea_gated;
  logic [NPH-1:0] noload;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  noload_gate #(.NPH(NPH), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid),
    .act_pwr(act_pwr), .rea_pwr(rea_pwr),
    .act_thr(act_thr), .rea_thr(rea_thr),
    .m_valid(m_valid), .act_gated(act_gated), .rea_gated(rea_gated),
    .noload(noload));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint mag28(input logic [DW-1:0] v);
    longint s = longint'(signed'(v));
    if (s == -(64'sd1 <<< 27)) return (64'sd1 <<< 27) - 1;
    return (s < 0) ? -s : s;
  endfunction

  function automatic bit exp_nl(input logic [DW-1:0] p, input logic [DW-1:0] q);
    longint tp = longint'(signed'(act_thr));
    longint tq = longint'(signed'(rea_thr));
    if (tp < 0) return 1'b0;
    if (mag28(p) > tp) return 1'b0;
    if (tq < 0) return 1'b1;
    return mag28(q) <= tq;
  endfunction

  // Apply one valid sample, then check every phase after the capturing edge
  task automatic apply(input string req, input logic [DW-1:0] p0, p1, p2, q0, q1, q2);
    logic [DW-1:0] pv[NPH];
    logic [DW-1:0] qv[NPH];
    pv[0] = p0; pv[1] = p1; pv[2] = p2;
    qv[0] = q0; qv[1] = q1; qv[2] = q2;
    @(negedge clk);
    for (int i = 0; i < NPH; i++) begin
      act_pwr[i*DW +: DW] = pv[i];
      rea_pwr[i*DW +: DW] = qv[i];
    end
    s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk("R2", "m_valid", longint'(m_valid), 1);
    for (int i = 0; i < NPH; i++) begin
      bit e = exp_nl(pv[i], qv[i]);
      chk(req, $sformatf("noload[%0d]", i), longint'(noload[i]), longint'(e));
      chk(req, $sformatf("act_gated[%0d]", i), longint'(act_gated[i*DW +: DW]),
          e ? 0 : longint'(pv[i]));
      chk(req, $sformatf("rea_gated[%0d]", i), longint'(rea_gated[i*DW +: DW]),
          e ? 0 : longint'(qv[i]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "m_valid", longint'(m_valid), 0);
    chk("R1", "noload", longint'(noload), 0);
    chk("R1", "act_gated", longint'(act_gated == '0), 1);
    chk("R1", "rea_gated", longint'(rea_gated == '0), 1);
  endtask

  task automatic t_both_below();  // R3, R5
    act_thr = 24'd1000; rea_thr = 24'd1000;
    apply("R3", 28'd1000, -28'sd1000, 28'd0, -28'sd1000, 28'd1000, 28'd5);
    act_thr = 24'd0; rea_thr = 24'd0;
    apply("R3", 28'd0, 28'd0, 28'd1, 28'd0, -28'sd1, 28'd0);
    chk("R5", "noload[0] zero thr", longint'(noload[0]), 1);
  endtask

  task automatic t_one_over();  // R4, R10
    act_thr = 24'd1000; rea_thr = 24'd1000;
    apply("R4", 28'd1001, 28'd0, 28'd5, 28'd0, -28'sd1001, 28'd5);
    chk("R10", "noload pattern", longint'(noload), 3'b100);
    apply("R10", 28'd3, -28'sd2000, 28'd999, 28'd4, 28'd7, 28'd1001);
    chk("R10", "noload pattern 2", longint'(noload), 3'b001);
  endtask

  task automatic t_wide();  // R6
    act_thr = 24'h7FFFFF; rea_thr = 24'h7FFFFF;
    apply("R6", 28'h07FFFFF, 28'h0800000, 28'd0, 28'd0, 28'd0, -28'sh7FFFFF);
    chk("R6", "noload wide", longint'(noload), 3'b101);
  endtask

  task automatic t_min();  // R7
    act_thr = 24'h7FFFFF; rea_thr = 24'h7FFFFF;
    apply("R7", 28'h8000000, 28'd0, -28'sd5, 28'd0, 28'h8000000, -28'sd6);
    chk("R7", "noload most negative", longint'(noload), 3'b100);
  endtask

  task automatic t_disabled();  // R8
    act_thr = 24'hFFFFFF; rea_thr = 24'd1000;
    apply("R8", 28'd0, 28'd0, 28'd0, 28'd0, 28'd0, 28'd0);
    chk("R8", "noload off", longint'(noload), 0);
    act_thr = 24'h800000; rea_thr = 24'h800000;
    apply("R8", 28'd0, 28'd12, -28'sd3, 28'd0, 28'd9, 28'd1);
    chk("R8", "noload off both neg", longint'(noload), 0);
  endtask

  task automatic t_act_only();  // R9
    act_thr = 24'd100; rea_thr = 24'h800000;
    apply("R9", 28'd50, 28'd200, -28'sd100, 28'h7FFFFFF, 28'd0, 28'h8000000);
    chk("R9", "noload active only", longint'(noload), 3'b101);
  endtask

  task automatic t_hold();  // R2
    logic [NPH*DW-1:0] a_snap, r_snap;
    logic [NPH-1:0]    n_snap;
    act_thr = 24'd10; rea_thr = 24'd10;
    apply("R2", 28'd1, 28'd50, 28'd2, 28'd1, 28'd3, 28'd2);
    a_snap = act_gated; r_snap = rea_gated; n_snap = noload;
    @(negedge clk);
    act_pwr = {3{28'd7}}; rea_pwr = {3{28'd900}};
    repeat (3) @(negedge clk);
    chk("R2", "m_valid idle", longint'(m_valid), 0);
    chk("R2", "noload held", longint'(noload), longint'(n_snap));
    chk("R2", "act held", longint'(act_gated == a_snap), 1);
    chk("R2", "rea held", longint'(rea_gated == r_snap), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_both_below();
    t_one_over();
    t_wide();
    t_min();
    t_disabled();
    t_act_only();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule